// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Generator

This block times programmed-I/O cycles on one IDE channel that carries a master and a slave device. A host raises a cycle request that names the target drive, the direction and the transfer width. The block then runs the cycle in three phases. It first drives the address and chip-select phase. It then asserts the read or write strobe. Finally it holds the bus idle for a recovery period, and after that it reports the cycle finished with a one-clock done pulse.

Each drive has its own timing set, held in a small configuration register file inside the block. A drive has three timing bytes: one for 16-bit reads, one for 16-bit writes, and one shared by 8-bit accesses in either direction. In each byte the upper nibble is the strobe (active) count and the lower nibble is the recovery count. A separate setup word holds one address-setup nibble per drive. Every field holds the wanted length in clocks minus one. Every field is 4 bits wide, so no phase can be longer than 16 clocks. That range covers PIO modes up to 4 at bus clocks from 25 to 33 MHz.

The sequencer takes a snapshot of the selected timing set when it accepts a request. A register write made while a cycle is running therefore takes effect from the next cycle. Read data from the device is captured on the last strobe clock. Write data is driven from the start of the setup phase until the strobe ends.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, every timing byte reads 0xFF and the setup word reads 0x000000FF. The block is idle: ready is high, and the chip-select, both strobes and done are low.
- R2: In a timing byte, bits 7:4 give the strobe length and bits 3:0 give the recovery length. A field value of N gives a phase of N+1 clocks, so a value of 0 gives a 1-clock phase.
- R3: Register address 3 (and its alias, address 7) is the setup word. Bits 3:0 hold the master's setup count and bits 7:4 hold the slave's. A write to the setup word changes only the nibbles whose enable bit is set: enable bit 0 selects the master nibble and enable bit 1 selects the slave nibble. The bits above 7 read as zero.
- R4: Addresses 0, 1 and 2 hold the master's 16-bit read, 16-bit write and 8-bit bytes. Addresses 4, 5 and 6 hold the same three bytes for the slave. Drive select 0 picks the master set and 1 picks the slave set. A 16-bit cycle uses the read byte or the write byte according to its direction, and an 8-bit cycle uses the 8-bit byte.
- R5: A cycle runs in this order. Chip-select is high with no strobe for setup+1 clocks. The read strobe (for reads) or the write strobe (for writes) is then high for active+1 clocks. Chip-select stays high with no strobe for recovery+1 clocks. Done is then high for one clock, and ready returns on the following clock.
- R6: A request is accepted only while ready is high. A request raised while a cycle is running is dropped, and it starts no cycle.
- R7: A read returns the data bus value that was present on the last strobe clock.
- R8: During a write, the data output enable is high, and the write data is on the bus, from the first setup clock through the last strobe clock. During a read the enable stays low.
- R9: A timing-register write made during a cycle does not change that cycle. The next cycle uses the new value.
- R10: A field value of 15 gives a 16-clock phase, and no phase ever lasts longer than 16 clocks.
- R11: An 8-bit read returns the low data byte with the upper byte set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: bit 2 selects the drive, bits 1:0 select the slot (3 = setup word) |
| cfg_wdata | input | 32 | Register write data |
| cfg_nib_en | input | 2 | Per-drive nibble enables for setup-word writes |
| cfg_rdata | output | 32 | Register read data at cfg_addr |
| req_valid | input | 1 | Cycle request |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_drive | input | 1 | 0 = master, 1 = slave |
| req_write | input | 1 | 1 = write cycle |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_wdata | input | 16 | Write data |
| bus_sel | output | 1 | Address/chip-select phase active (setup, strobe, recovery) |
| bus_drive | output | 1 | Drive addressed by the running cycle |
| ior | output | 1 | Read strobe, active high |
| iow | output | 1 | Write strobe, active high |
| dd_out | output | 16 | Data driven to the device |
| dd_oe | output | 1 | Data output enable |
| dd_in | input | 16 | Data from the device |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-clock cycle-complete pulse |

## Verification
The bench builds the block with its default parameters. These are a 32-bit register word, 4-bit count fields and a 16-bit data bus. With these values the reset timings of 16 clocks per phase, and the 1-clock minimum, are both within reach of short runs. The bench changes the data bus on every strobe clock, so a capture one clock early or one clock late shows up as a wrong value. It also programs a distinct byte into each timing slot, so a wrong slot or a wrong drive shows up as a wrong phase length.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;
  parameter int FIELD_W    = 4;
  parameter int NUM_DRIVES = 2;
  parameter int ADDR_W     = 3;
  localparam int BYTE_W    = 2 * FIELD_W;
  localparam int SLOTS     = 3;
  localparam logic [1:0] SETUP_SLOT = 2'd3;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV, PH_DONE} phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] active;
    logic [FIELD_W-1:0] recov;
  } timing_t;

  // slot 0: 16-bit read, slot 1: 16-bit write, slot 2: 8-bit either direction
  function automatic logic [1:0] slot_for(input logic wide, input logic write);
    return wide ? (write ? 2'd1 : 2'd0) : 2'd2;
  endfunction

  function automatic logic [FIELD_W-1:0] active_of(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:FIELD_W];
  endfunction

  function automatic logic [FIELD_W-1:0] recov_of(input logic [BYTE_W-1:0] b);
    return b[FIELD_W-1:0];
  endfunction
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_strobe_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic [NUM_DRIVES-1:0] cfg_nib_en,
  output logic [CFG_W-1:0]      cfg_rdata,
  input  logic                  lk_drive,
  input  logic [1:0]            lk_slot,
  output timing_t               lk_tim
);
  logic [BYTE_W-1:0]  slot_q  [NUM_DRIVES][SLOTS];
  logic [FIELD_W-1:0] setup_q [NUM_DRIVES];

  logic       addr_drive;
  logic [1:0] addr_slot;
  assign addr_drive = cfg_addr[ADDR_W-1];
  assign addr_slot  = cfg_addr[1:0];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        setup_q[d] <= '1;
        for (int s = 0; s < SLOTS; s++) slot_q[d][s] <= '1;
      end else if (cfg_we) begin
        if (addr_slot == SETUP_SLOT) begin
          if (cfg_nib_en[d]) setup_q[d] <= cfg_wdata[d*FIELD_W +: FIELD_W];
        end else if (addr_drive == 1'(d)) begin
          for (int s = 0; s < SLOTS; s++)
            if (addr_slot == 2'(s)) slot_q[d][s] <= cfg_wdata[BYTE_W-1:0];
        end
      end
    end

    // R3: storage of a drive changes only through a register write
    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(setup_q[d]) && $stable(slot_q[d][0]) &&
                   $stable(slot_q[d][1]) && $stable(slot_q[d][2])));
  end

  always_comb begin
    cfg_rdata = '0;
    if (addr_slot == SETUP_SLOT) begin
      for (int d = 0; d < NUM_DRIVES; d++) cfg_rdata[d*FIELD_W +: FIELD_W] = setup_q[d];
    end else begin
      for (int s = 0; s < SLOTS; s++)
        if (addr_slot == 2'(s)) cfg_rdata[BYTE_W-1:0] = slot_q[addr_drive][s];
    end
  end

  always_comb begin
    lk_tim       = '1;
    lk_tim.setup = setup_q[lk_drive];
    for (int s = 0; s < SLOTS; s++)
      if (lk_slot == 2'(s)) begin
        lk_tim.active = active_of(slot_q[lk_drive][s]);
        lk_tim.recov  = recov_of(slot_q[lk_drive][s]);
      end
  end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_strobe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_drive,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  timing_t           tim,
  output logic              bus_sel,
  output logic              bus_drive,
  output logic              ior,
  output logic              iow,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  input  logic [DATA_W-1:0] dd_in,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam int RUN_W  = FIELD_W + 2;
  localparam int MAX_RUN = 1 << FIELD_W;

  phase_e             phase_q;
  logic [FIELD_W-1:0] cnt_q;
  timing_t            tim_q;
  logic               wr_q, wide_q, drive_q;
  logic [DATA_W-1:0]  wdata_q, rd_q;
  logic [RUN_W-1:0]   run_q;

  // named internal events
  logic accept, phase_last, strobe_last;
  assign accept      = req_valid && (phase_q == PH_IDLE);
  assign phase_last  = (cnt_q == '0);
  assign strobe_last = (phase_q == PH_ACTIVE) && phase_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tim_q   <= '1;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      drive_q <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_SETUP;
          cnt_q   <= tim.setup;
          tim_q   <= tim;
          wr_q    <= req_write;
          wide_q  <= req_wide;
          drive_q <= req_drive;
          wdata_q <= req_wdata;
        end
        PH_SETUP: if (phase_last) begin
          phase_q <= PH_ACTIVE;
          cnt_q   <= tim_q.active;
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACTIVE: if (phase_last) begin
          phase_q <= PH_RECOV;
          cnt_q   <= tim_q.recov;
          if (!wr_q) rd_q <= wide_q ? dd_in : {{HALF_W{1'b0}}, dd_in[HALF_W-1:0]};
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV: if (phase_last) phase_q <= PH_DONE;
                  else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // length of the current phase, for the bound check
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (accept || (phase_q != PH_IDLE && phase_last)) run_q <= RUN_W'(1);
    else if (phase_q != PH_IDLE && run_q <= RUN_W'(MAX_RUN)) run_q <= run_q + 1'b1;
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign bus_sel   = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE) || (phase_q == PH_RECOV);
  assign bus_drive = drive_q;
  assign ior       = (phase_q == PH_ACTIVE) && !wr_q;
  assign iow       = (phase_q == PH_ACTIVE) && wr_q;
  assign dd_oe     = wr_q && ((phase_q == PH_SETUP) || (phase_q == PH_ACTIVE));
  assign dd_out    = wdata_q;
  assign rd_data   = rd_q;

  assert_strobe_after_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ior || iow) |-> $past(phase_q) == PH_SETUP);
  assert_done_then_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE) |=> req_ready);
  assert_setup_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP && $past(phase_q) != PH_SETUP) |-> $past(req_valid && req_ready));
  assert_capture_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_q) |-> $past(strobe_last && !wr_q));
  assert_oe_ends_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dd_oe) |-> $past(iow));
  assert_snapshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(tim_q));
  assert_phase_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(MAX_RUN));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic [NUM_DRIVES-1:0] cfg_nib_en,
  output logic [CFG_W-1:0]      cfg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_drive,
  input  logic                  req_write,
  input  logic                  req_wide,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  bus_sel,
  output logic                  bus_drive,
  output logic                  ior,
  output logic                  iow,
  output logic [DATA_W-1:0]     dd_out,
  output logic                  dd_oe,
  input  logic [DATA_W-1:0]     dd_in,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  done
);
  timing_t    sel_tim;
  logic [1:0] sel_slot;
  logic       seq_done_unused;

  assign sel_slot = slot_for(req_wide, req_write);

  pio_timing_regs #(.CFG_W(CFG_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_nib_en(cfg_nib_en), .cfg_rdata(cfg_rdata),
    .lk_drive(req_drive), .lk_slot(sel_slot), .lk_tim(sel_tim)
  );

  pio_cycle_seq #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_drive(req_drive), .req_write(req_write), .req_wide(req_wide),
    .req_wdata(req_wdata), .tim(sel_tim), .bus_sel(bus_sel), .bus_drive(bus_drive),
    .ior(ior), .iow(iow), .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in),
    .rd_data(rd_data)
  );

  // done: one clock after recovery, before idle (neither selected nor ready)
  assign seq_done_unused = 1'b0;
  assign done = !bus_sel && !req_ready && !seq_done_unused;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/pio_strobe_gen_tb_top.sv
module pio_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  cfg_nib_en = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_ready, req_drive = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_wdata = '0, dd_out, dd_in = '0, rd_data;
  logic        bus_sel, bus_drive, ior, iow, dd_oe, done;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_tb [2][3];
  logic [3:0] m_su [2];

  always #2 clk = ~clk;

  pio_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_nib_en(cfg_nib_en), .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_drive(req_drive), .req_write(req_write), .req_wide(req_wide), .req_wdata(req_wdata),
    .bus_sel(bus_sel), .bus_drive(bus_drive), .ior(ior), .iow(iow), .dd_out(dd_out),
    .dd_oe(dd_oe), .dd_in(dd_in), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_of(input bit wide, input bit wr);
    if (!wide) return 2;
    return wr ? 1 : 0;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [2:0] a);
    if (a[1:0] == 2'd3) return {24'h0, m_su[1], m_su[0]};
    return {24'h0, m_tb[a[2]][a[1:0]]};
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [31:0] d, input logic [1:0] ne);
    if (a[1:0] == 2'd3) begin
      if (ne[0]) m_su[0] = d[3:0];
      if (ne[1]) m_su[1] = d[7:4];
    end else m_tb[a[2]][a[1:0]] = d[7:0];
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d, input logic [1:0] ne);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_nib_en = ne;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d, ne);
  endtask

  task automatic cfg_check(input logic [2:0] a, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp_rdata(a), req, $sformatf("readback addr %0d", a), cfg_rdata, exp_rdata(a));
  endtask

  // Runs one cycle and checks phase lengths, strobe, data enable and read data.
  task automatic run_cycle(input bit drv, input bit wr, input bit wide, input logic [15:0] wd,
                           input bit mid_wr, input logic [2:0] mid_a, input logic [31:0] mid_d,
                           input bit poke, input string req);
    int es, ea, er, ns, na, nr, oe_bad, st_bad, guard;
    bit seen;
    logic [15:0] last_in;
    logic [7:0] b;
    b  = m_tb[drv][slot_of(wide, wr)];
    es = int'(m_su[drv]) + 1;
    ea = int'(b[7:4]) + 1;
    er = int'(b[3:0]) + 1;
    ns = 0; na = 0; nr = 0; oe_bad = 0; st_bad = 0; guard = 0; seen = 0; last_in = '0;
    @(negedge clk);
    req_valid = 1'b1; req_drive = drv; req_write = wr; req_wide = wide; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 200) begin
      if (bus_sel) begin
        if (ior || iow) begin
          na++; seen = 1;
          if (ior == wr || iow != wr || bus_drive != drv) st_bad++;
        end else if (!seen) ns++;
        else nr++;
      end
      if (dd_oe != (wr && bus_sel && !(seen && !(ior || iow)))) oe_bad++;
      if (dd_oe && dd_out != wd) oe_bad++;
      if (ior || iow) begin
        dd_in = 16'($urandom);
        last_in = dd_in;
      end
      if (mid_wr) begin
        cfg_we = (ior || iow) && na == 1;
        cfg_addr = mid_a; cfg_wdata = mid_d; cfg_nib_en = 2'b11;
        if (cfg_we) model_write(mid_a, mid_d, 2'b11);
      end
      if (poke) begin
        req_valid = (ior || iow) && na == 1;
        req_drive = ~drv;
      end
      @(negedge clk);
      guard++;
    end
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(done, "R5", "done reached", int'(done), 1);
    chk(ns == es, "R5", "setup clocks", ns, es);
    chk(na == ea, "R2", "strobe clocks", na, ea);
    chk(nr == er, "R2", "recovery clocks", nr, er);
    chk(st_bad == 0, req, "strobe kind or drive", st_bad, 0);
    chk(oe_bad == 0, "R8", "data enable/data", oe_bad, 0);
    if (!wr) begin
      if (wide) chk(rd_data == last_in, "R7", "read data", rd_data, last_in);
      else chk(rd_data == {8'h00, last_in[7:0]}, "R11", "8-bit read data", rd_data, {8'h00, last_in[7:0]});
    end
    @(negedge clk);
    chk(req_ready && !bus_sel, poke ? "R6" : "R5", "idle after done", {req_ready, bus_sel}, 2'b10);
    if (poke) begin
      @(negedge clk);
      chk(!bus_sel && req_ready, "R6", "dropped request started nothing", bus_sel, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    for (int d = 0; d < 2; d++) begin
      m_su[d] = 4'hF;
      for (int s = 0; s < 3; s++) m_tb[d][s] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values and idle outputs
    chk(req_ready && !bus_sel && !ior && !iow && !done, "R1", "idle after reset",
        {req_ready, bus_sel, ior, iow, done}, 5'b10000);
    for (int a = 0; a < 8; a++) cfg_check(3'(a), "R1");
    // R10 / R1: slowest timing, 16 clocks per phase
    run_cycle(1'b0, 1'b0, 1'b1, 16'h0, 0, '0, '0, 0, "R10");
    // R3: master nibble only, slave nibble stays
    cfg_write(3'd3, 32'h0000_00A0, 2'b01);
    cfg_check(3'd3, "R3");
    cfg_write(3'd0, 32'h0000_0000, 2'b00);
    cfg_check(3'd0, "R2");
    run_cycle(1'b0, 1'b0, 1'b1, 16'h0, 0, '0, '0, 0, "R2");
    // R3: slave nibble only, master nibble stays 0; upper bits ignored
    cfg_write(3'd7, 32'hFFFF_FF25, 2'b10);
    cfg_check(3'd3, "R3");
    // R4: distinct slave bytes
    cfg_write(3'd4, 32'h0000_0021, 2'b00);
    cfg_write(3'd5, 32'h0000_0043, 2'b00);
    cfg_write(3'd6, 32'h0000_0065, 2'b00);
    cfg_check(3'd5, "R4");
    run_cycle(1'b1, 1'b0, 1'b1, 16'h0, 0, '0, '0, 0, "R4");
    run_cycle(1'b1, 1'b1, 1'b1, 16'hBEEF, 0, '0, '0, 0, "R4");
    run_cycle(1'b1, 1'b0, 1'b0, 16'h0, 0, '0, '0, 0, "R11");
    run_cycle(1'b1, 1'b1, 1'b0, 16'h1234, 0, '0, '0, 0, "R8");
    // R9: write slave write byte mid-cycle; old timing now, new next
    run_cycle(1'b1, 1'b1, 1'b1, 16'h5A5A, 1, 3'd5, 32'h0000_0010, 0, "R9");
    cfg_check(3'd5, "R9");
    run_cycle(1'b1, 1'b1, 1'b1, 16'hA5A5, 0, '0, '0, 0, "R9");
    // R6: request raised while busy is dropped
    run_cycle(1'b0, 1'b0, 1'b0, 16'h0, 0, '0, '0, 1, "R6");
    // random mix
    for (int i = 0; i < 30; i++) begin
      if (($urandom % 2) == 0)
        cfg_write(3'($urandom), $urandom, 2'($urandom));
      run_cycle(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 0, '0, '0, 0, "R4");
    end
    for (int a = 0; a < 8; a++) cfg_check(3'(a), "R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule